// File: doc/BRIEF.md
# ARP Request Responder

This block sits on the receive side of an Ethernet port and answers address resolution requests for the local station. Frames arrive as 64-bit stream beats. The first byte of a frame on the wire is in bits 7:0 of the first beat, and each later byte takes the next higher lane. The block parses the link and ARP headers as the beats go past. It keeps the requester's hardware and protocol addresses. When a well-formed request for the local IPv4 address ends cleanly, it emits a complete 64-byte reply frame on the output stream.

The local MAC address and local IPv4 address are static inputs. They use the same lane order as the stream: the first wire byte is in bits 7:0. The block never sends a reply for a frame that carries the error sideband flag on any beat, for a frame with a wrong header, for a frame that ends too early, or for a frame that asks for another address. Only one reply is held at a time. The input is stalled until that reply has left.

Top module: `arp_reply_engine`

## Requirements
- R1: After reset, `rpl_valid` is low and `req_ready` is high.
- R2: A valid request for the local address produces exactly one reply. The reply is 8 beats long. Every beat has `rpl_keep` = 8'hFF and `rpl_user` = 0. `rpl_last` is high on the eighth beat only.
- R3: Reply byte layout uses the lane order above: bytes 0-5 are the requester's sender MAC (request bytes 22-27); bytes 6-11 are `local_mac`; bytes 12-21 are 08 06 00 01 08 00 06 04 00 02; bytes 22-27 are `local_mac`; bytes 28-31 are `local_ip`; bytes 32-37 are the requester's sender MAC; bytes 38-41 are the requester's sender IP (request bytes 28-31).
- R4: Reply bytes 42 through 63 are zero.
- R5: A frame with `req_user` high on any accepted beat gives no reply. An identical clean frame after it gives exactly one reply.
- R6: A request whose target IP (request bytes 38-41) differs from `local_ip` gives no reply.
- R7: A frame whose bytes 12-21 differ from 08 06 00 01 08 00 06 04 00 01 (ethertype, hardware type, protocol type, lengths, opcode = request) gives no reply.
- R8: A frame whose `req_last` comes before its sixth beat gives no reply. The next frame is parsed from its first beat. `req_keep` is not examined.
- R9: Idle cycles between input beats (`req_valid` low) do not change the result.
- R10: While `rpl_valid` is high and `rpl_ready` is low, all reply outputs hold their values.
- R11: `req_ready` is low from the cycle after the last request beat is accepted until the last reply beat is accepted.
- R12: The first reply beat becomes valid in the cycle right after the request's last beat is accepted. No beat is presented earlier, so a `req_user` on the final beat still cancels the reply.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| local_mac | input | 48 | Station MAC, first wire byte in bits 7:0 |
| local_ip | input | 32 | Station IPv4, first wire byte in bits 7:0 |
| req_data | input | 64 | Incoming frame beat |
| req_valid | input | 1 | Incoming beat valid |
| req_ready | output | 1 | Incoming beat accepted |
| req_keep | input | 8 | Incoming byte enables (unused) |
| req_last | input | 1 | Last beat of incoming frame |
| req_user | input | 1 | Incoming frame error flag |
| rpl_data | output | 64 | Reply beat |
| rpl_valid | output | 1 | Reply beat valid |
| rpl_ready | input | 1 | Reply beat taken downstream |
| rpl_keep | output | 8 | Reply byte enables |
| rpl_last | output | 1 | Last reply beat |
| rpl_user | output | 1 | Reply error flag, always zero |

## Verification
The accept/reject decision is due one cycle after the edge that takes the last input beat. At that point `rpl_valid` and the first reply word appear, and `req_ready` falls. Each following reply word is due one cycle after the previous one is taken. The bench keeps a behavioural model that is updated at each falling edge from the handshakes about to complete. It compares `rpl_valid`, `req_ready` and every presented word with the model at that same falling edge. Per-scenario reply counts are checked after the output has drained.

// File: rtl/arp_reply_engine.sv
module arp_reply_engine (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [47:0] local_mac,
  input  logic [31:0] local_ip,
  input  logic [63:0] req_data,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic [7:0]  req_keep,
  input  logic        req_last,
  input  logic        req_user,
  output logic [63:0] rpl_data,
  output logic        rpl_valid,
  input  logic        rpl_ready,
  output logic [7:0]  rpl_keep,
  output logic        rpl_last,
  output logic        rpl_user
);
  localparam logic [31:0] TYPE_WORD  = 32'h0100_0608;
  localparam logic [47:0] ARP_WORD   = 48'h0100_0406_0008;
  localparam logic [15:0] OP_ANSWER  = 16'h0200;
  localparam logic [2:0]  LAST_HDR   = 3'd5;

  logic [2:0]  in_idx, out_idx;
  logic        drop, busy, take, beat_bad, frame_ok;
  logic [47:0] peer_mac;
  logic [31:0] peer_ip;
  logic [511:0] frame;
  logic        unused_keep;

  assign unused_keep = ^req_keep;
  assign req_ready   = !busy;
  assign take        = req_valid && req_ready;

  always_comb begin
    beat_bad = req_user;
    case (in_idx)
      3'd1:    if (req_data[63:32] != TYPE_WORD) beat_bad = 1'b1;
      3'd2:    if (req_data[47:0] != ARP_WORD) beat_bad = 1'b1;
      3'd4:    if (req_data[63:48] != local_ip[15:0]) beat_bad = 1'b1;
      3'd5:    if (req_data[15:0] != local_ip[31:16]) beat_bad = 1'b1;
      default: ;
    endcase
    if (req_last && in_idx < LAST_HDR) beat_bad = 1'b1;
  end

  assign frame_ok = !drop && !beat_bad;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      in_idx   <= '0;
      out_idx  <= '0;
      drop     <= 1'b0;
      busy     <= 1'b0;
      peer_mac <= '0;
      peer_ip  <= '0;
    end else begin
      if (take) begin
        if (in_idx == 3'd2) peer_mac[15:0] <= req_data[63:48];
        if (in_idx == 3'd3) begin
          peer_mac[47:16] <= req_data[31:0];
          peer_ip         <= req_data[63:32];
        end
        if (req_last) begin
          in_idx <= '0;
          drop   <= 1'b0;
          busy   <= frame_ok;
        end else begin
          if (in_idx != 3'd7) in_idx <= in_idx + 3'd1;
          drop <= drop || beat_bad;
        end
      end
      if (busy && rpl_ready) begin
        out_idx <= out_idx + 3'd1;
        if (out_idx == 3'd7) busy <= 1'b0;
      end
    end
  end

  assign frame = {176'd0, peer_ip, peer_mac, local_ip, local_mac, OP_ANSWER,
                  8'h04, 8'h06, 16'h0008, 16'h0100, 16'h0608, local_mac, peer_mac};

  assign rpl_data  = frame[{out_idx, 6'd0} +: 64];
  assign rpl_valid = busy;
  assign rpl_keep  = 8'hFF;
  assign rpl_last  = busy && (out_idx == 3'd7);
  assign rpl_user  = 1'b0;

  assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rpl_valid && !rpl_ready |=> rpl_valid && $stable(rpl_data) && $stable(rpl_last));

  assert_stall_R11: assert property (@(posedge clk) disable iff (!rst_n)
    rpl_valid |-> !req_ready);

  assert_beat_shape_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rpl_valid |-> (rpl_keep == 8'hFF) && !rpl_user);

  assert_drain_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rpl_valid && rpl_ready && rpl_last |=> !rpl_valid && req_ready);

  assert_clean_end_R12: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rpl_valid) |-> $past(req_valid && req_ready && req_last && !req_user));
endmodule

// File: tb/test_arp_reply_engine.sv
`timescale 1ns/1ps
module test_arp_reply_engine;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [47:0] local_mac = 48'h02BE_E736_7101;
  logic [31:0] local_ip  = 32'h0403_0201;
  logic [63:0] req_data = '0;
  logic req_valid = 1'b0, req_last = 1'b0, req_user = 1'b0;
  logic [7:0] req_keep = 8'hFF;
  logic req_ready, rpl_valid, rpl_last, rpl_user;
  logic rpl_ready = 1'b1;
  logic [63:0] rpl_data;
  logic [7:0] rpl_keep;

  int checks = 0, bad = 0, replies = 0, cyc = 0;
  bit done = 0, bp = 0;
  logic [7:0] fb [64];
  logic [7:0] mb [64];
  int mn = 0;
  bit mu = 0;
  logic [63:0] expq [$];
  logic [63:0] prev_data;
  bit prev_stall = 0;

  arp_reply_engine i_arp_reply_engine (.*);

  always #2.5 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    #1;
    rpl_ready = bp ? (($urandom % 3) != 0) : 1'b1;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      done = 1;
      chk(0, "watchdog", cyc, 0);
      $display("test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  end

  // behavioural model, evaluated before the coming rising edge
  always @(negedge clk) begin
    if (rst_n) begin
      chk(rpl_valid == (expq.size() > 0), "R12 valid timing", rpl_valid, expq.size() > 0);
      chk(req_ready == (expq.size() == 0), "R11 input stall", req_ready, expq.size() == 0);
      if (prev_stall) chk(rpl_data == prev_data, "R10 hold", rpl_data, prev_data);
      prev_stall = rpl_valid && !rpl_ready;
      prev_data  = rpl_data;
      if (rpl_valid && expq.size() > 0) begin
        chk(rpl_data == expq[0], (expq.size() <= 3) ? "R4 padding" : "R3 content", rpl_data, expq[0]);
        chk(rpl_keep == 8'hFF && !rpl_user, "R2 keep/user", {rpl_user, rpl_keep}, 9'h0FF);
        chk(rpl_last == (expq.size() == 1), "R2 last", rpl_last, expq.size() == 1);
        if (rpl_ready) begin
          void'(expq.pop_front());
          if (rpl_last) replies++;
        end
      end
      if (req_valid && req_ready) begin
        if (mn < 8) for (int j = 0; j < 8; j++) mb[mn*8+j] = req_data[8*j +: 8];
        mn++;
        mu = mu | req_user;
        if (req_last) begin
          bit ok;
          logic [7:0] r [64];
          ok = (mn >= 6) && !mu &&
               mb[12] == 8'h08 && mb[13] == 8'h06 && mb[14] == 8'h00 && mb[15] == 8'h01 &&
               mb[16] == 8'h08 && mb[17] == 8'h00 && mb[18] == 8'h06 && mb[19] == 8'h04 &&
               mb[20] == 8'h00 && mb[21] == 8'h01;
          for (int j = 0; j < 4; j++) if (mb[38+j] != local_ip[8*j +: 8]) ok = 0;
          if (ok) begin
            for (int j = 0; j < 64; j++) r[j] = 8'h00;
            for (int j = 0; j < 6; j++) begin
              r[j] = mb[22+j]; r[6+j] = local_mac[8*j +: 8];
              r[22+j] = local_mac[8*j +: 8]; r[32+j] = mb[22+j];
            end
            r[12] = 8'h08; r[13] = 8'h06; r[14] = 8'h00; r[15] = 8'h01; r[16] = 8'h08;
            r[17] = 8'h00; r[18] = 8'h06; r[19] = 8'h04; r[20] = 8'h00; r[21] = 8'h02;
            for (int j = 0; j < 4; j++) begin
              r[28+j] = local_ip[8*j +: 8]; r[38+j] = mb[28+j];
            end
            for (int w = 0; w < 8; w++) begin
              logic [63:0] word;
              for (int j = 0; j < 8; j++) word[8*j +: 8] = r[8*w+j];
              expq.push_back(word);
            end
          end
          mn = 0; mu = 0;
        end
      end
    end
  end

  task automatic make_req(input logic [47:0] sha, input logic [31:0] spa, input logic [31:0] tpa);
    for (int j = 0; j < 64; j++) fb[j] = 8'h00;
    for (int j = 0; j < 6; j++) begin
      fb[j] = 8'hFF; fb[6+j] = sha[8*j +: 8]; fb[22+j] = sha[8*j +: 8];
    end
    fb[12] = 8'h08; fb[13] = 8'h06; fb[14] = 8'h00; fb[15] = 8'h01; fb[16] = 8'h08;
    fb[17] = 8'h00; fb[18] = 8'h06; fb[19] = 8'h04; fb[20] = 8'h00; fb[21] = 8'h01;
    for (int j = 0; j < 4; j++) begin
      fb[28+j] = spa[8*j +: 8]; fb[38+j] = tpa[8*j +: 8];
    end
  endtask

  task automatic send(input int nbeats, input int user_beat, input int gap);
    for (int b = 0; b < nbeats; b++) begin
      for (int j = 0; j < 8; j++) req_data[8*j +: 8] = fb[8*b+j];
      req_valid = 1'b1;
      req_last  = (b == nbeats - 1);
      req_user  = (b == user_beat);
      forever begin
        @(negedge clk);
        if (req_ready) break;
      end
      @(posedge clk); #1;
      req_valid = 1'b0; req_last = 1'b0; req_user = 1'b0;
      repeat (gap) @(posedge clk);
      #0;
    end
  endtask

  task automatic expect_replies(input int n, input string tag);
    repeat (80) @(posedge clk);
    chk(replies == n, tag, replies, n);
    replies = 0;
  endtask

  initial begin
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk(!rpl_valid && req_ready, "R1 reset state", {rpl_valid, req_ready}, 2'b01);
    @(posedge clk); #1;

    make_req(48'h0101_010D_D000, 32'h0A01_0B02, local_ip);
    send(8, -1, 0);
    expect_replies(1, "R2 single reply");

    bp = 1;
    make_req(48'h5544_3322_1100, 32'hC0A8_0001, local_ip);
    send(8, -1, 3);
    expect_replies(1, "R9 gaps with backpressure R10");

    send(8, 3, 2);
    expect_replies(0, "R5 errored frame dropped");
    send(8, -1, 2);
    expect_replies(1, "R5 clean copy answered");

    send(8, 7, 0);
    expect_replies(0, "R12 error on last beat");

    make_req(48'hAABB_CCDD_EEFF, 32'h1111_2222, 32'h0403_0202);
    send(8, -1, 0);
    expect_replies(0, "R6 other address");

    make_req(48'hAABB_CCDD_EEFF, 32'h1111_2222, local_ip);
    fb[21] = 8'h02;
    send(8, -1, 0);
    expect_replies(0, "R7 wrong opcode");
    fb[21] = 8'h01; fb[13] = 8'h00;
    send(8, -1, 0);
    expect_replies(0, "R7 wrong ethertype");
    fb[13] = 8'h06; fb[18] = 8'h08;
    send(8, -1, 1);
    expect_replies(0, "R7 wrong length");
    fb[18] = 8'h06;

    send(5, -1, 0);
    expect_replies(0, "R8 short frame dropped");
    send(6, -1, 0);
    expect_replies(1, "R8 six-beat frame answered");

    bp = 0;
    send(8, -1, 0);
    make_req(48'h1234_5678_9ABC, 32'h0102_0304, local_ip);
    send(8, -1, 0);
    expect_replies(2, "R11 second request stalled then answered");

    bp = 1;
    for (int k = 0; k < 6; k++) begin
      make_req({16'h0, $urandom}, $urandom, (k % 2 == 0) ? local_ip : local_ip ^ 32'h1);
      send(8, -1, k);
    end
    expect_replies(3, "R6 mixed targets");

    done = 1;
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end
endmodule